// File: doc/BRIEF.md
# Eight-Function 8-bit ALU

This block is a purely combinational arithmetic logic unit. It takes two 8-bit operands and a 3-bit operation code and returns an 8-bit result together with three single-bit status flags: Zero, CarryOut and Overflow. Eight function units work in parallel on the same operands. These are bitwise AND, bitwise OR, bitwise invert, left shift, arithmetic right shift, add, subtract and a 4x4 unsigned multiply. An 8-to-1 multiplexer indexed by the operation code then picks one unit's output as the result.

Add and subtract share one ripple-carry chain. For subtraction, operand B is complemented and the carry into bit 0 is forced to 1. The block holds no state and uses no clock. A surrounding datapath can place it between operand registers and a result register, and the whole evaluation fits in one cycle.

Top module: `alu8_core`

## Requirements
- R1: The operation code is decoded as 0 AND, 1 OR, 2 INV, 3 SHL, 4 SHR, 5 ADD, 6 SUB, 7 MUL. For code 0 the result is A & B, and for code 1 it is A | B.
- R2: For SHL (code 3) the result is A shifted left by B[2:0] places, and the vacated low bits are filled with 0.
- R3: For SHR (code 4) the result is A shifted right by B[2:0] places, and the vacated high bits are filled with copies of A[7].
- R4: For ADD (code 5) the result is (A + B) mod 256, and CarryOut is bit 8 of the 9-bit sum.
- R5: For SUB (code 6) the result is (A - B) mod 256, computed as A + ~B + 1. CarryOut is the carry from bit 7 of that sum, so it is 1 exactly when A >= B unsigned.
- R6: For ADD and SUB, Overflow is 1 exactly when the two adder inputs (A and B, or A and ~B) share a sign bit and the result's sign bit differs from it.
- R7: For MUL (code 7) the result is the unsigned product A[3:0] * B[3:0]. Bits A[7:4] and B[7:4] have no effect on it.
- R8: Zero is 1 exactly when all eight result bits are 0, whatever the operation.
- R9: CarryOut and Overflow are both 0 for every operation other than ADD and SUB.
- R10: Operand B has no effect for INV, whose result is ~A. Bits B[7:3] have no effect for SHL and SHR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 8 | First operand |
| opb | input | 8 | Second operand; its low 3 bits give the shift amount |
| op_sel | input | 3 | Operation code |
| result | output | 8 | Selected function-unit output |
| zero | output | 1 | Result is all zeros |
| carry_out | output | 1 | Carry from bit 7 of the adder, ADD/SUB only |
| overflow | output | 1 | Signed overflow of the adder, ADD/SUB only |

## Verification
The immediate assertions inside the RTL re-evaluate whenever an operand or the operation code changes, and they assume that every input bit holds a known 0 or 1. The bench therefore drives all three inputs together from a single task, always with defined values, and samples the outputs half a cycle later. The stimulus covers the sign-boundary operands that trigger overflow in both directions, equal operands for subtraction, and every shift amount from 0 to 7. It also sets the operand bits that must be ignored, using values chosen so that any leak of those bits would change the result.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DW      = 8;
    localparam int OP_W    = 3;
    localparam int N_LANES = 1 << OP_W;
    localparam int MW      = DW / 2;
    localparam int SH_W    = $clog2(DW);

    typedef enum logic [OP_W-1:0] {
        OP_AND = 3'd0,
        OP_OR  = 3'd1,
        OP_INV = 3'd2,
        OP_SHL = 3'd3,
        OP_SHR = 3'd4,
        OP_ADD = 3'd5,
        OP_SUB = 3'd6,
        OP_MUL = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic zero;
        logic carry;
        logic ovf;
    } alu_flags_t;

    function automatic logic uses_adder(input alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

endpackage

// File: rtl/alu8_bitlanes.sv
module alu8_bitlanes
    import alu8_pkg::*;
#(
    parameter int W   = DW,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [SHW-1:0] amt,
    output logic [W-1:0]   y_and,
    output logic [W-1:0]   y_or,
    output logic [W-1:0]   y_inv,
    output logic [W-1:0]   y_shl,
    output logic [W-1:0]   y_shr
);

    assign y_and = a & b;
    assign y_or  = a | b;
    assign y_inv = ~a;

    // Logarithmic barrel shifters: stage s moves by 2**s when amt[s] is set
    logic [W-1:0] lstage [SHW+1];
    logic [W-1:0] rstage [SHW+1];

    assign lstage[0] = a;
    assign rstage[0] = a;

    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int D = 1 << s;
        logic [W-1:0] lmov;
        logic [W-1:0] rmov;
        assign lmov = {lstage[s][W-1-D:0], {D{1'b0}}};
        assign rmov = {{D{a[W-1]}}, rstage[s][W-1:D]};
        assign lstage[s+1] = amt[s] ? lmov : lstage[s];
        assign rstage[s+1] = amt[s] ? rmov : rstage[s];
    end

    assign y_shl = lstage[SHW];
    assign y_shr = rstage[SHW];

    always_comb begin
        AST_SHL_LOW_CLEAR: assert ((y_shl & ((W'(1) << amt) - W'(1))) == '0)
            else $error("shl left nonzero low bits"); // R2
        AST_SHR_SIGN_FILL: assert (!(a[W-1] && amt != '0) || y_shr[W-1])
            else $error("shr lost sign fill"); // R3
    end

endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);

    logic [W-1:0] b_eff;
    logic [W:0]   cy;

    assign b_eff = b ^ {W{sub}};
    assign cy[0] = sub;

    for (genvar i = 0; i < W; i++) begin : g_fa
        logic p;
        assign p       = a[i] ^ b_eff[i];
        assign sum[i]  = p ^ cy[i];
        assign cy[i+1] = (a[i] & b_eff[i]) | (p & cy[i]);
    end

    assign cout = cy[W];
    assign ovf  = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);

    always_comb begin
        AST_RIPPLE_SUM: assert ({cout, sum} ==
                                ({1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub}))
            else $error("ripple chain mismatch"); // R4
    end

endmodule

// File: rtl/alu8_mul.sv
module alu8_mul
    import alu8_pkg::*;
#(
    parameter int N = MW
) (
    input  logic [N-1:0]   a,
    input  logic [N-1:0]   b,
    output logic [2*N-1:0] prod
);

    logic [2*N-1:0] pp [N];

    for (genvar i = 0; i < N; i++) begin : g_pp
        assign pp[i] = b[i] ? ({{N{1'b0}}, a} << i) : '0;
    end

    always_comb begin
        prod = '0;
        for (int i = 0; i < N; i++) begin
            prod = prod + pp[i];
        end
    end

    always_comb begin
        AST_MUL_RANGE: assert (prod <= ((2*N)'((1 << N) - 1) * (2*N)'((1 << N) - 1)))
            else $error("product beyond nibble range"); // R7
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic [7:0] opa,
    input  logic [7:0] opb,
    input  logic [2:0] op_sel,
    output logic [7:0] result,
    output logic       zero,
    output logic       carry_out,
    output logic       overflow
);

    alu_op_e    op;
    alu_flags_t flg;
    logic [DW-1:0] lane [N_LANES];

    logic [DW-1:0] add_sum;
    logic          add_cout;
    logic          add_ovf;

    assign op = alu_op_e'(op_sel);

    alu8_bitlanes #(.W(DW), .SHW(SH_W)) u_bits (
        .a     (opa),
        .b     (opb),
        .amt   (opb[SH_W-1:0]),
        .y_and (lane[OP_AND]),
        .y_or  (lane[OP_OR]),
        .y_inv (lane[OP_INV]),
        .y_shl (lane[OP_SHL]),
        .y_shr (lane[OP_SHR])
    );

    alu8_addsub #(.W(DW)) u_adder (
        .a    (opa),
        .b    (opb),
        .sub  (op == OP_SUB),
        .sum  (add_sum),
        .cout (add_cout),
        .ovf  (add_ovf)
    );

    assign lane[OP_ADD] = add_sum;
    assign lane[OP_SUB] = add_sum;

    alu8_mul #(.N(MW)) u_mul (
        .a    (opa[MW-1:0]),
        .b    (opb[MW-1:0]),
        .prod (lane[OP_MUL])
    );

    // 8-to-1 result multiplexer, one lane per function unit
    assign result = lane[op];

    always_comb begin
        flg.zero  = (result == '0);
        flg.carry = uses_adder(op) & add_cout;
        flg.ovf   = uses_adder(op) & add_ovf;
    end

    assign zero      = flg.zero;
    assign carry_out = flg.carry;
    assign overflow  = flg.ovf;

    always_comb begin
        AST_CARRY_ARITH_ONLY: assert (uses_adder(op) || !carry_out)
            else $error("carry outside add/sub"); // R9
        AST_OVF_ARITH_ONLY: assert (uses_adder(op) || !overflow)
            else $error("overflow outside add/sub"); // R9
        AST_SUB_NO_BORROW: assert (op != OP_SUB || (carry_out == (opa >= opb)))
            else $error("sub carry not no-borrow"); // R5
        AST_ZERO_MATCH: assert (zero == (lane[op] == '0))
            else $error("zero flag mismatch"); // R8
    end

endmodule

// File: tb/alu8_core_test.sv
`timescale 1ns/1ps
module alu8_core_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;   // 250 MHz

    logic [7:0] opa, opb;
    logic [2:0] op_sel;
    logic [7:0] result;
    logic       zero, carry_out, overflow;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    alu8_core uut (
        .opa       (opa),
        .opb       (opb),
        .op_sel    (op_sel),
        .result    (result),
        .zero      (zero),
        .carry_out (carry_out),
        .overflow  (overflow)
    );

    // Independent reference built from the requirement text
    function automatic logic [10:0] model(input logic [2:0] o,
                                          input logic [7:0] a,
                                          input logic [7:0] b);
        logic [7:0] r;
        logic       c, v;
        logic [8:0] w;
        int sa, sb, sr;
        c = 1'b0;
        v = 1'b0;
        case (o)
            3'd0: r = a & b;
            3'd1: r = a | b;
            3'd2: r = ~a;
            3'd3: r = a << b[2:0];
            3'd4: r = 8'($signed(a) >>> b[2:0]);
            3'd5: begin
                w = {1'b0, a} + {1'b0, b};
                r = w[7:0];
                c = w[8];
                sa = int'($signed(a)); sb = int'($signed(b));
                sr = sa + sb;
                v = (sr > 127) || (sr < -128);
            end
            3'd6: begin
                r = a - b;
                c = (a >= b);
                sa = int'($signed(a)); sb = int'($signed(~b));
                v = (a[7] == ~b[7]) && (r[7] != a[7]);
            end
            default: r = 8'({4'b0, a[3:0]} * {4'b0, b[3:0]});
        endcase
        return {r, (r == 8'h00), c, v};
    endfunction

    task automatic apply(input logic [2:0] o, input logic [7:0] a, input logic [7:0] b);
        @(posedge clk);
        op_sel = o; opa = a; opb = b;
        @(negedge clk);
    endtask

    task automatic check_all(input string req, input logic [2:0] o,
                             input logic [7:0] a, input logic [7:0] b);
        logic [10:0] exp;
        logic [10:0] got;
        apply(o, a, b);
        exp = model(o, a, b);
        got = {result, zero, carry_out, overflow};
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%h b=%h: got res=%h z=%b c=%b v=%b, expected res=%h z=%b c=%b v=%b",
                     req, o, a, b, got[10:3], got[2], got[1], got[0],
                     exp[10:3], exp[2], exp[1], exp[0]);
        end
    endtask

    task automatic check_val(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h, expected %h", req, got, exp);
        end
    endtask

    task automatic t_reset_state();
        apply(3'd0, 8'h00, 8'h00);
        check_val("R8 idle result", result, 8'h00);
        check_val("R8 idle zero", {7'b0, zero}, 8'h01);
        check_val("R9 idle flags", {6'b0, carry_out, overflow}, 8'h00);
    endtask

    task automatic t_logic();
        apply(3'd0, 8'h55, 8'hAA);
        check_val("R1 and", result, 8'h00);
        apply(3'd1, 8'h55, 8'hAA);
        check_val("R1 or", result, 8'hFF);
        check_all("R1 and mix", 3'd0, 8'hF0, 8'h3C);
        check_all("R1 or mix", 3'd1, 8'h81, 8'h18);
    endtask

    task automatic t_invert();
        apply(3'd2, 8'h55, 8'h00);
        check_val("R10 inv b=00", result, 8'hAA);
        apply(3'd2, 8'h55, 8'hFF);
        check_val("R10 inv b=FF", result, 8'hAA);
    endtask

    task automatic t_shifts();
        for (int k = 0; k < 8; k++) begin
            check_all("R2 shl", 3'd3, 8'h2B, 8'(k));
            check_all("R3 shr pos", 3'd4, 8'h2B, 8'(k));
            check_all("R3 shr neg", 3'd4, 8'hA6, 8'(k));
        end
        apply(3'd3, 8'h2B, 8'hFA);   // amount 2 with high bits set
        check_val("R10 shl upper b", result, 8'hAC);
        apply(3'd4, 8'h96, 8'hF9);   // amount 1
        check_val("R10 shr upper b", result, 8'hCB);
    endtask

    task automatic t_add();
        check_all("R4 add small", 3'd5, 8'h12, 8'h34);
        check_all("R4 add carry", 3'd5, 8'hFF, 8'h01);
        check_all("R6 add pos ovf", 3'd5, 8'h7F, 8'h01);
        check_all("R6 add neg ovf", 3'd5, 8'h80, 8'h80);
        check_all("R6 add mixed", 3'd5, 8'h80, 8'h7F);
        apply(3'd5, 8'h64, 8'h64);
        check_val("R6 add 100+100", {6'b0, carry_out, overflow}, 8'h01);
    endtask

    task automatic t_sub();
        check_all("R5 sub gt", 3'd6, 8'h50, 8'h20);
        check_all("R5 sub lt", 3'd6, 8'h20, 8'h50);
        check_all("R6 sub ovf", 3'd6, 8'h80, 8'h01);
        check_all("R6 sub ovf2", 3'd6, 8'h7F, 8'hFF);
        apply(3'd6, 8'h3C, 8'h3C);
        check_val("R5 sub equal", {result[5:0], zero, carry_out}, 8'h03);
        check_val("R8 sub equal zero", {7'b0, zero}, 8'h01);
    endtask

    task automatic t_mul();
        apply(3'd7, 8'h03, 8'h02);
        check_val("R7 mul 3x2", result, 8'h06);
        apply(3'd7, 8'hFF, 8'hFF);
        check_val("R7 mul 15x15 upper ignored", result, 8'hE1);
        apply(3'd7, 8'hA0, 8'h57);
        check_val("R7 mul zero nibble", {result[6:0], zero}, 8'h01);
        check_all("R7 mul mix", 3'd7, 8'h3D, 8'hC9);
    endtask

    task automatic t_nonarith_flags();
        for (int o = 0; o < 8; o++) begin
            if (o == 5 || o == 6) continue;
            apply(3'(o), 8'hFF, 8'hFF);
            check_val("R9 flags clear", {6'b0, carry_out, overflow}, 8'h00);
        end
        check_all("R8 zero via shl", 3'd3, 8'h80, 8'h01);
    endtask

    initial begin
        op_sel = 3'd0; opa = 8'h00; opb = 8'h00;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_logic();
        t_invert();
        t_shifts();
        t_add();
        t_sub();
        t_mul();
        t_nonarith_flags();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule